// File: doc/BRIEF.md
# SPI Serial Clock Divider with Linear and Power-of-Two Modes

This block turns a fast module clock into the timing for an SPI serial clock. A single configuration word holds two divider fields and a mode bit. Either a linear divider sets the half-period to (field + 1) module cycles, or a power-of-two divider sets it to 2^field module cycles. The full serial clock period is twice the half-period in both modes.

While the transfer-active input is high, the block issues a one-cycle half-period pulse at every serial clock edge and toggles a serial clock level output. A second pulse marks the leading edges, where the clock leaves its idle level. A shift engine next to the block uses these pulses to launch and sample data. While no transfer is active, the counter is held at its reload value and the clock rests at the idle polarity. A new transfer therefore always starts with a full-length half-period. A configuration write also restarts the count, so the new rate applies from a clean boundary.

Top module: `spi_sclk_divgen`

## Requirements
- R1: On a cycle with `cfg_wr` high, `cfg_wdata` is stored. Bit 12 is the mode: 1 is linear and 0 is power-of-two. Bits 7:0 are the linear field and bits 11:8 are the power-of-two field. The field that belongs to the other mode has no effect on timing.
- R2: In linear mode, consecutive `half_tick` pulses during a transfer are (linear field + 1) cycles apart. This covers field values from 0 (a pulse every cycle) to 255 (256 cycles).
- R3: In power-of-two mode, consecutive `half_tick` pulses are 2^field cycles apart. This covers field values from 0 (1 cycle) to 15 (32768 cycles).
- R4: Let L be the half-period length in cycles and let S be the first clock edge at which `xfer_active` is sampled high after being low. The first `half_tick` of the transfer is seen after edge S+L-1, and the k-th pulse after edge S+kL-1. This holds even when an earlier transfer was cut off mid-count.
- R5: A configuration write at edge W during a transfer gives no pulse at W. The following pulses, with the new length Lnew, are seen after edges W+Lnew, W+2·Lnew, and so on.
- R6: While `xfer_active` is low, `half_tick` and `lead_tick` stay low. From the edge after the transfer ends, `sclk` equals `cpol`.
- R7: During a transfer, `sclk` changes level in exactly the cycles in which `half_tick` is high. The k-th pulse of a transfer leaves `sclk` at `cpol` XOR (k odd).
- R8: `lead_tick` is high together with the odd-numbered pulses of a transfer, where `sclk` moves away from `cpol`. It is low on the even-numbered pulses.
- R9: After reset, the configuration is all zeros (power-of-two mode, field 0, one-cycle half-period), and `half_tick`, `lead_tick` and `sclk` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 13 | Configuration word: mode bit, power-of-two field, linear field |
| xfer_active | input | 1 | High for the duration of a transfer |
| cpol | input | 1 | Idle level of the serial clock |
| half_tick | output | 1 | One-cycle pulse at each serial clock edge |
| lead_tick | output | 1 | One-cycle pulse at each edge leaving the idle level |
| sclk | output | 1 | Serial clock level |

## Verification
The assertions assume that `cpol` does not change while a transfer is active. This matters because the leading-edge check compares `sclk` with the idle level sampled one cycle earlier. The bench sets `cpol` only while `xfer_active` has been low for several cycles. It ends each transfer right after the last expected pulse, so no pulse falls in the gap between the scoreboard's expectation and the drop of `xfer_active`. Configuration writes go in while idle, apart from one write placed deliberately mid-transfer, before the first pulse, to exercise the restart behaviour.

// File: rtl/spi_div_pkg.sv
// Package: shared defaults and the divider mode encoding for the SPI
// serial clock divider. The mode value matches the mode bit of the
// configuration word.
package spi_div_pkg;

    localparam int DEF_LIN_W = 8;
    localparam int DEF_EXP_W = 4;

    typedef enum logic {
        DIV_POW2   = 1'b0,
        DIV_LINEAR = 1'b1
    } div_mode_e;

endpackage

// File: rtl/sdiv_decode.sv
// sdiv_decode: turns a configuration word into a half-period reload
// value (half-period length minus one).
// Assumes: the word is laid out as {mode, pow2 field, linear field}, and
// CNT_W >= max(LIN_W, 2**EXP_W - 1), so every length fits.
module sdiv_decode #(
    parameter int LIN_W = spi_div_pkg::DEF_LIN_W,
    parameter int EXP_W = spi_div_pkg::DEF_EXP_W,
    parameter int CNT_W = 15,
    localparam int REG_W = LIN_W + EXP_W + 1
) (
    input  logic [REG_W-1:0] cfg,
    output logic [CNT_W-1:0] reload
);
    import spi_div_pkg::*;

    logic [LIN_W-1:0] lin_field;
    logic [EXP_W-1:0] pow_field;
    div_mode_e        mode;

    // Split the word into its fields and pick the formula for the mode.
    always_comb begin
        lin_field = cfg[LIN_W-1:0];
        pow_field = cfg[LIN_W+EXP_W-1:LIN_W];
        mode      = div_mode_e'(cfg[REG_W-1]);
        if (mode == DIV_LINEAR) begin
            reload = CNT_W'(lin_field);
        end else begin
            // 2^field - 1 as a mask of field low ones
            reload = ~({CNT_W{1'b1}} << pow_field);
        end
    end

endmodule

// File: rtl/sdiv_cfg_reg.sv
// sdiv_cfg_reg: holds the configuration word. It provides the reload value
// for the stored word and for the word being written, so that a write can
// restart the counter with the new length in the same edge.
// Assumes: cfg_wr is a single-cycle or level strobe in the module clock domain.
module sdiv_cfg_reg #(
    parameter int LIN_W = spi_div_pkg::DEF_LIN_W,
    parameter int EXP_W = spi_div_pkg::DEF_EXP_W,
    parameter int CNT_W = 15,
    localparam int REG_W = LIN_W + EXP_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [REG_W-1:0] cfg_wdata,
    output logic [CNT_W-1:0] reload_cur,
    output logic [CNT_W-1:0] reload_new
);
    logic [REG_W-1:0] cfg_q;
    logic [REG_W-1:0] dec_in  [2];
    logic [CNT_W-1:0] dec_out [2];

    // Store the configuration word on a write; clear it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (cfg_wr) begin
            cfg_q <= cfg_wdata;
        end
    end

    assign dec_in[0] = cfg_q;
    assign dec_in[1] = cfg_wdata;

    // Two identical decoders: one for the stored word, one for the incoming word.
    for (genvar g = 0; g < 2; g++) begin : g_dec
        sdiv_decode #(
            .LIN_W(LIN_W),
            .EXP_W(EXP_W),
            .CNT_W(CNT_W)
        ) dec_i (
            .cfg   (dec_in[g]),
            .reload(dec_out[g])
        );
    end

    assign reload_cur = dec_out[0];
    assign reload_new = dec_out[1];

endmodule

// File: rtl/sdiv_halfcnt.sv
// sdiv_halfcnt: down-counter that measures one half-period. It is held at
// the reload value while idle, restarts on a configuration write, and
// raises tick in the cycle it reaches zero while a transfer is active.
// Assumes: reload_new is valid whenever cfg_wr is high.
module sdiv_halfcnt #(
    parameter int CNT_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             cfg_wr,
    input  logic [CNT_W-1:0] reload_cur,
    input  logic [CNT_W-1:0] reload_new,
    output logic             tick
);
    logic [CNT_W-1:0] cnt_q;
    logic             at_zero;

    assign at_zero = (cnt_q == '0);
    // A write takes priority over an expiring count.
    assign tick    = active && !cfg_wr && at_zero;

    // Count down while active; reload on write, while idle, or after expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cfg_wr) begin
            cnt_q <= reload_new;
        end else if (!active || at_zero) begin
            cnt_q <= reload_cur;
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

endmodule

// File: rtl/sdiv_edge_gen.sv
// sdiv_edge_gen: registers the half-period pulse, toggles the serial clock
// level on each pulse, and marks the pulses that leave the idle level.
// Assumes: cpol is constant during a transfer.
module sdiv_edge_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic cpol,
    input  logic tick,
    output logic half_tick,
    output logic lead_tick,
    output logic sclk
);
    // Serial clock level: idle polarity when inactive, toggled on each pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk <= 1'b0;
        end else if (!active) begin
            sclk <= cpol;
        end else if (tick) begin
            sclk <= ~sclk;
        end
    end

    // Registered edge pulses, aligned with the new serial clock level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            half_tick <= 1'b0;
            lead_tick <= 1'b0;
        end else begin
            half_tick <= tick;
            lead_tick <= tick && (sclk == cpol);
        end
    end

endmodule

// File: rtl/spi_sclk_divgen.sv
// spi_sclk_divgen: SPI serial clock divider with a linear mode and a
// power-of-two mode, selected by the mode bit of a configuration word.
// Produces a half-period pulse, a leading-edge pulse and the clock level.
// Assumes: a single clock domain, synchronous active-low reset, and cpol
// held steady while xfer_active is high.
module spi_sclk_divgen #(
    parameter int LIN_W = spi_div_pkg::DEF_LIN_W,
    parameter int EXP_W = spi_div_pkg::DEF_EXP_W,
    localparam int REG_W = LIN_W + EXP_W + 1,
    localparam int POW_MAX = (1 << EXP_W) - 1,
    localparam int CNT_W = (LIN_W > POW_MAX) ? LIN_W : POW_MAX
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [REG_W-1:0] cfg_wdata,
    input  logic             xfer_active,
    input  logic             cpol,
    output logic             half_tick,
    output logic             lead_tick,
    output logic             sclk
);
    logic [CNT_W-1:0] reload_cur;
    logic [CNT_W-1:0] reload_new;
    logic             tick;

    sdiv_cfg_reg #(
        .LIN_W(LIN_W),
        .EXP_W(EXP_W),
        .CNT_W(CNT_W)
    ) cfg_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_wdata (cfg_wdata),
        .reload_cur(reload_cur),
        .reload_new(reload_new)
    );

    sdiv_halfcnt #(
        .CNT_W(CNT_W)
    ) cnt_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (xfer_active),
        .cfg_wr    (cfg_wr),
        .reload_cur(reload_cur),
        .reload_new(reload_new),
        .tick      (tick)
    );

    sdiv_edge_gen edge_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (xfer_active),
        .cpol     (cpol),
        .tick     (tick),
        .half_tick(half_tick),
        .lead_tick(lead_tick),
        .sclk     (sclk)
    );

endmodule

// File: rtl/spi_sclk_divgen_chk.sv
// spi_sclk_divgen_chk: temporal checks on the divider's ports, bound to
// the top module.
// Assumes: cpol is steady during a transfer.
module spi_sclk_divgen_chk (
    input logic clk,
    input logic rst_n,
    input logic cfg_wr,
    input logic xfer_active,
    input logic cpol,
    input logic half_tick,
    input logic lead_tick,
    input logic sclk
);
    // R6: clock settles to idle polarity one edge after an idle cycle
    p_idle_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_active |=> (sclk == $past(cpol)));

    // R6: no pulses come from an idle cycle
    p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_active |=> (!half_tick && !lead_tick));

    // R7: each pulse comes with a level change
    p_toggle_on_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
        half_tick |-> (sclk != $past(sclk)));

    // R7: no level change during a transfer without a pulse
    p_hold_between_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(xfer_active) && !half_tick) |-> $stable(sclk));

    // R8: a leading pulse is always a half-period pulse
    p_lead_is_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
        lead_tick |-> half_tick);

    // R8: a leading pulse leaves the clock away from its idle level
    p_lead_leaves_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        lead_tick |-> (sclk != $past(cpol)));

    // R5: a write cancels any pulse in its own cycle
    p_write_restarts_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> !half_tick);

endmodule

bind spi_sclk_divgen spi_sclk_divgen_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_wr     (cfg_wr),
    .xfer_active(xfer_active),
    .cpol       (cpol),
    .half_tick  (half_tick),
    .lead_tick  (lead_tick),
    .sclk       (sclk)
);

// File: tb/spi_sclk_divgen_tb_top.sv
// Scoreboard bench: driver tasks push expected pulses (cycle, lead flag,
// clock level), and a monitor pops and compares them as pulses appear.
module spi_sclk_divgen_tb_top;

    localparam int REG_W = 13;

    typedef struct {
        int    cyc;
        bit    lead;
        bit    lvl;
        string tag;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             cfg_wr;
    logic [REG_W-1:0] cfg_wdata;
    logic             xfer_active;
    logic             cpol;
    logic             half_tick;
    logic             lead_tick;
    logic             sclk;

    int   cyc = 0;
    int   n_checks = 0;
    int   n_errors = 0;
    exp_t exp_q[$];

    always #10 clk = ~clk;

    spi_sclk_divgen dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_wr     (cfg_wr),
        .cfg_wdata  (cfg_wdata),
        .xfer_active(xfer_active),
        .cpol       (cpol),
        .half_tick  (half_tick),
        .lead_tick  (lead_tick),
        .sclk       (sclk)
    );

    function automatic logic [REG_W-1:0] lin_cfg(input int f);
        return {1'b1, 4'h0, 8'(f)};
    endfunction

    function automatic logic [REG_W-1:0] pow_cfg(input int f);
        return {1'b0, 4'(f), 8'h00};
    endfunction

    // Count edges, then compare each pulse with the head of the queue.
    always @(posedge clk) begin
        #2;
        cyc++;
        if (rst_n && half_tick) begin
            n_checks++;
            if (exp_q.size() == 0) begin
                n_errors++;
                $display("FAIL R7/R8: unexpected pulse at cycle %0d, expected none", cyc);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                if (e.cyc != cyc || e.lead != lead_tick || e.lvl != sclk) begin
                    n_errors++;
                    $display("FAIL %s (R7/R8): pulse cycle=%0d lead=%0b sclk=%0b, expected cycle=%0d lead=%0b sclk=%0b",
                             e.tag, cyc, lead_tick, sclk, e.cyc, e.lead, e.lvl);
                end
            end
        end
    end

    task automatic push_ticks(input int base, input int len, input int n, input string tag);
        for (int k = 1; k <= n; k++) begin
            exp_t e;
            e.cyc  = base + k * len - 1;
            e.lead = (k % 2) == 1;
            e.lvl  = cpol ^ ((k % 2) == 1);
            e.tag  = tag;
            exp_q.push_back(e);
        end
    endtask

    task automatic write_cfg(input logic [REG_W-1:0] v);
        @(negedge clk);
        cfg_wr    = 1'b1;
        cfg_wdata = v;
        @(negedge clk);
        cfg_wr    = 1'b0;
    endtask

    // Run a transfer of n half-periods of length len and drop it after the last.
    task automatic run_xfer(input int len, input int n, input string tag);
        int s;
        @(negedge clk);
        s = cyc + 1;
        push_ticks(s, len, n, tag);
        xfer_active = 1'b1;
        while (cyc < s + n * len - 1) @(negedge clk);
        xfer_active = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    // Idle window: no pulses and clock at idle polarity (R6).
    task automatic check_idle(input int ncyc, input string tag);
        bit bad = 0;
        for (int i = 0; i < ncyc; i++) begin
            @(negedge clk);
            if (sclk !== cpol || half_tick !== 1'b0 || lead_tick !== 1'b0) bad = 1;
        end
        n_checks++;
        if (bad) begin
            n_errors++;
            $display("FAIL %s: idle sclk=%0b half_tick=%0b, expected sclk=%0b half_tick=0",
                     tag, sclk, half_tick, cpol);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
        $finish;
    end

    initial begin
        rst_n       = 1'b0;
        cfg_wr      = 1'b0;
        cfg_wdata   = '0;
        xfer_active = 1'b0;
        cpol        = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R9: reset outputs
        n_checks++;
        if (half_tick !== 1'b0 || lead_tick !== 1'b0 || sclk !== 1'b0) begin
            n_errors++;
            $display("FAIL R9: after reset half=%0b lead=%0b sclk=%0b, expected 0 0 0",
                     half_tick, lead_tick, sclk);
        end
        // R9: default configuration gives a one-cycle half-period
        run_xfer(1, 6, "R9");
        check_idle(5, "R6");

        // R2: linear mode, middle value and both boundaries
        write_cfg(lin_cfg(4));
        run_xfer(5, 4, "R2");
        write_cfg(lin_cfg(0));
        run_xfer(1, 3, "R2");
        write_cfg(lin_cfg(255));
        run_xfer(256, 2, "R2");

        // R3: power-of-two mode, small value and the largest exponent
        write_cfg(pow_cfg(3));
        run_xfer(8, 4, "R3");
        write_cfg(pow_cfg(0));
        run_xfer(1, 4, "R3");
        write_cfg(pow_cfg(15));
        run_xfer(32768, 1, "R3");

        // R1: the other mode's field has no effect
        write_cfg({1'b1, 4'hF, 8'd2});
        run_xfer(3, 4, "R1");
        write_cfg({1'b0, 4'd2, 8'hFF});
        run_xfer(4, 3, "R1");

        // R6: idle level follows cpol high, and transfers start from it
        cpol = 1'b1;
        check_idle(20, "R6");
        run_xfer(4, 5, "R6");
        check_idle(10, "R6");
        cpol = 1'b0;
        check_idle(10, "R6");

        // R4: cut a transfer mid-count, then restart with a full first half-period
        write_cfg(lin_cfg(6));
        @(negedge clk);
        xfer_active = 1'b1;
        repeat (3) @(negedge clk);
        xfer_active = 1'b0;
        @(negedge clk);
        run_xfer(7, 2, "R4");
        run_xfer(7, 3, "R4");

        // R5: write during a transfer before the first pulse
        write_cfg(lin_cfg(9));
        begin
            int s;
            int w;
            @(negedge clk);
            s = cyc + 1;
            xfer_active = 1'b1;
            repeat (4) @(negedge clk);
            w = cyc + 1;
            cfg_wr    = 1'b1;
            cfg_wdata = lin_cfg(2);
            push_ticks(w + 1, 3, 4, "R5");
            @(negedge clk);
            cfg_wr = 1'b0;
            while (cyc < w + 12) @(negedge clk);
            xfer_active = 1'b0;
            repeat (3) @(negedge clk);
        end
        check_idle(5, "R6");

        // R7: every expected pulse was seen
        n_checks++;
        if (exp_q.size() != 0) begin
            n_errors++;
            $display("FAIL R7: %0d expected pulses missing, expected 0", exp_q.size());
        end

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule